// File: doc/BRIEF.md
# Index-Parity Branch-Free Select Datapath

This block takes a loop body with a data-dependent branch and turns it into pure computation, so that a stream of loop iterations can pass through without stalling. Each cycle it may accept one iteration: an index and a window of four unsigned 8-bit elements, called w0 to w3 here. Two arms are evaluated in parallel on every accepted iteration. The product arm computes w0*w1 and the sum arm computes w2+w3. Bit 0 of the index then picks which arm's result is delivered. An even index delivers the product and an odd index delivers the sum.

Both arms are registered once, so there is one cycle of latency. A small route register travels alongside the arm registers and holds the valid bit, the parity and the output mode of the iteration in flight. Its states are ROUTE_IDLE, ROUTE_MERGE_PROD, ROUTE_MERGE_SUM, ROUTE_SPLIT_PROD and ROUTE_SPLIT_SUM. On each clock edge the register moves to the state picked by the current input. ROUTE_IDLE is the target when no iteration is offered or when reset is high. A valid iteration goes to MERGE or SPLIT according to the mode input, and to PROD or SUM according to the index parity. All transitions are possible from every state.

In merged mode the selected result appears on a single valid/data output. In split mode each arm has its own destination port with its own write enable. The parity raises exactly one of those enables and leaves the other destination unwritten. Fetching the elements from memory is left to the surrounding logic.

Top module: `parsel_datapath`

## Requirements
- R1: With merge mode (`in_split`=0) and an even index, `res_valid` is 1 one cycle after the input is taken, and `res_data` equals w0*w1 as a 16-bit unsigned product.
- R2: With merge mode and an odd index, `res_valid` is 1 one cycle later, and `res_data` equals w2+w3 zero-extended to 16 bits.
- R3: A new iteration is taken on every cycle that `in_valid` is 1, with no stall. A stream of back-to-back valid inputs gives back-to-back results, each result one cycle after its input.
- R4: When `in_valid` is 0 on a cycle, `res_valid`, `prod_we` and `sum_we` are all 0 on the following cycle.
- R5: With split mode (`in_split`=1) and an even index, the next cycle has `prod_we`=1, `prod_data`=w0*w1 and `sum_we`=0. With split mode and an odd index, the next cycle has `sum_we`=1, `sum_data`=w2+w3 and `prod_we`=0. In split mode `res_valid` stays 0.
- R6: In merge mode, `prod_we` and `sum_we` stay 0.
- R7: A synchronous active-high `rst` sets the route register to ROUTE_IDLE. After any clock edge with `rst`=1, all three enables are 0, even if `in_valid` was 1.
- R8: At most one of `res_valid`, `prod_we` and `sum_we` is 1 in any cycle.
- R9: Only bit 0 of `in_idx` decides the arm. The other index bits have no effect, for example with index values 0xFFFF and 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An iteration is offered this cycle |
| in_idx | input | 16 | Loop index; bit 0 selects the arm |
| in_w0 | input | 8 | Window element 0 (product operand) |
| in_w1 | input | 8 | Window element 1 (product operand) |
| in_w2 | input | 8 | Window element 2 (sum operand) |
| in_w3 | input | 8 | Window element 3 (sum operand) |
| in_split | input | 1 | 1 = separate destination ports, 0 = merged output |
| res_valid | output | 1 | Merged result valid |
| res_data | output | 16 | Merged result |
| prod_we | output | 1 | Write enable of the product destination |
| prod_data | output | 16 | Product destination data |
| sum_we | output | 1 | Write enable of the sum destination |
| sum_data | output | 16 | Sum destination data |

## Verification
Several properties are checked on every clock edge after reset by the assertions:
- The arithmetic value delivered for even and odd indices in merge mode.
- The one-cycle hand-off from a valid input to an enable.
- The quiet cycle that follows an idle input.
- Which destination port is written in split mode.
- That the three enables are mutually exclusive.

Other behaviours only the bench scenarios can show:
- That a reset cycle holding a live iteration swallows it.
- The extreme operand values (255*255 and 255+255).
- That wide index values such as 0xFFFF and 0xFFFE are decided by bit 0 alone.
- That a mixed stream alternating modes and parities delivers the correct value in every consecutive slot.

// File: rtl/parsel_pkg.sv
package parsel_pkg;

    localparam int ELEM_W = 8;
    localparam int IDX_W  = 16;
    localparam int RES_W  = 2 * ELEM_W;

    // Where the iteration held in the pipeline register is delivered
    typedef enum logic [2:0] {
        ROUTE_IDLE       = 3'd0,
        ROUTE_MERGE_PROD = 3'd1,
        ROUTE_MERGE_SUM  = 3'd2,
        ROUTE_SPLIT_PROD = 3'd3,
        ROUTE_SPLIT_SUM  = 3'd4
    } route_e;

endpackage

// File: rtl/parsel_arms.sv
module parsel_arms #(
    parameter int ELEM_W = 8,
    parameter int RES_W  = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic [ELEM_W-1:0] w0,
    input  logic [ELEM_W-1:0] w1,
    input  logic [ELEM_W-1:0] w2,
    input  logic [ELEM_W-1:0] w3,
    output logic [RES_W-1:0]  prod_q,
    output logic [RES_W-1:0]  sum_q
);

    // Both arms run on every accepted iteration; nothing waits for parity
    logic [RES_W-1:0] prod_d;
    logic [RES_W-1:0] sum_d;

    always_comb begin
        prod_d = RES_W'(w0) * RES_W'(w1);
        sum_d  = RES_W'(w2) + RES_W'(w3);
    end

    always_ff @(posedge clk) begin
        if (en) begin
            prod_q <= prod_d;
            sum_q  <= sum_d;
        end
    end

endmodule

// File: rtl/parsel_ctrl.sv
module parsel_ctrl
    import parsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   in_odd,
    input  logic   in_split,
    output route_e route_q
);

    route_e route_d;

    // Next-route decode: parity and mode travel with the valid bit
    always_comb begin
        route_d = ROUTE_IDLE;
        if (in_valid) begin
            unique case ({in_split, in_odd})
                2'b00:   route_d = ROUTE_MERGE_PROD;
                2'b01:   route_d = ROUTE_MERGE_SUM;
                2'b10:   route_d = ROUTE_SPLIT_PROD;
                default: route_d = ROUTE_SPLIT_SUM;
            endcase
        end
    end

    // Route register, aligned with the arm registers
    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= ROUTE_IDLE;
        end else begin
            route_q <= route_d;
        end
    end

    // R4: an idle input cycle leaves the route idle on the next cycle
    p_route_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (route_q == ROUTE_IDLE));

endmodule

// File: rtl/parsel_select.sv
module parsel_select
    import parsel_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  route_e           route_q,
    input  logic [RES_W-1:0] prod_q,
    input  logic [RES_W-1:0] sum_q,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             prod_we,
    output logic             sum_we
);

    // Parity mux and write-enable decode
    always_comb begin
        res_valid = 1'b0;
        res_data  = prod_q;
        prod_we   = 1'b0;
        sum_we    = 1'b0;
        unique case (route_q)
            ROUTE_IDLE: begin
                res_valid = 1'b0;
            end
            ROUTE_MERGE_PROD: begin
                res_valid = 1'b1;
                res_data  = prod_q;
            end
            ROUTE_MERGE_SUM: begin
                res_valid = 1'b1;
                res_data  = sum_q;
            end
            ROUTE_SPLIT_PROD: begin
                prod_we = 1'b1;
            end
            ROUTE_SPLIT_SUM: begin
                sum_we = 1'b1;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/parsel_datapath.sv
module parsel_datapath
    import parsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [ELEM_W-1:0] in_w0,
    input  logic [ELEM_W-1:0] in_w1,
    input  logic [ELEM_W-1:0] in_w2,
    input  logic [ELEM_W-1:0] in_w3,
    input  logic              in_split,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data,
    output logic              prod_we,
    output logic [RES_W-1:0]  prod_data,
    output logic              sum_we,
    output logic [RES_W-1:0]  sum_data
);

    route_e           route_q;
    logic [RES_W-1:0] prod_q;
    logic [RES_W-1:0] sum_q;

    parsel_arms #(
        .ELEM_W (ELEM_W),
        .RES_W  (RES_W)
    ) u_arms (
        .clk    (clk),
        .en     (in_valid),
        .w0     (in_w0),
        .w1     (in_w1),
        .w2     (in_w2),
        .w3     (in_w3),
        .prod_q (prod_q),
        .sum_q  (sum_q)
    );

    parsel_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_odd   (in_idx[0]),
        .in_split (in_split),
        .route_q  (route_q)
    );

    parsel_select #(
        .RES_W (RES_W)
    ) u_select (
        .route_q   (route_q),
        .prod_q    (prod_q),
        .sum_q     (sum_q),
        .res_valid (res_valid),
        .res_data  (res_data),
        .prod_we   (prod_we),
        .sum_we    (sum_we)
    );

    assign prod_data = prod_q;
    assign sum_data  = sum_q;

    // R1: even index, merged output carries the product
    p_even_prod_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_split && !in_idx[0]) |=>
        (res_valid && res_data == RES_W'($past(in_w0)) * RES_W'($past(in_w1))));

    // R2: odd index, merged output carries the sum
    p_odd_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_split && in_idx[0]) |=>
        (res_valid && res_data == RES_W'($past(in_w2)) + RES_W'($past(in_w3))));

    // R3: every valid input yields an enable on the next cycle
    p_no_stall_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (res_valid || prod_we || sum_we));

    // R5: split mode writes the product port for even indices
    p_split_prod_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_split && !in_idx[0]) |=>
        (prod_we && !sum_we && !res_valid
         && prod_data == RES_W'($past(in_w0)) * RES_W'($past(in_w1))));

    // R5: split mode writes the sum port for odd indices
    p_split_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_split && in_idx[0]) |=>
        (sum_we && !prod_we && !res_valid
         && sum_data == RES_W'($past(in_w2)) + RES_W'($past(in_w3))));

    // R6: merge mode leaves both destination enables low
    p_merge_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_split) |=> (!prod_we && !sum_we));

    // R8: enables are mutually exclusive
    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, prod_we, sum_we}));

endmodule

// File: tb/test_parsel_datapath.sv
`timescale 1ns/1ps
module test_parsel_datapath;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_idx = '0;
    logic [7:0]  in_w0 = '0;
    logic [7:0]  in_w1 = '0;
    logic [7:0]  in_w2 = '0;
    logic [7:0]  in_w3 = '0;
    logic        in_split = 1'b0;
    logic        res_valid;
    logic [15:0] res_data;
    logic        prod_we;
    logic [15:0] prod_data;
    logic        sum_we;
    logic [15:0] sum_data;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    parsel_datapath i_parsel_datapath (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_idx    (in_idx),
        .in_w0     (in_w0),
        .in_w1     (in_w1),
        .in_w2     (in_w2),
        .in_w3     (in_w3),
        .in_split  (in_split),
        .res_valid (res_valid),
        .res_data  (res_data),
        .prod_we   (prod_we),
        .prod_data (prod_data),
        .sum_we    (sum_we),
        .sum_data  (sum_data)
    );

    // Row: {valid, split, idx[15:0], w0, w1, w2, w3, kind[1:0], expected[15:0]}
    // kind: 0 = no enable, 1 = merged result, 2 = product port, 3 = sum port
    localparam int NVEC = 12;
    localparam logic [67:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 16'd0,      8'd3,   8'd5,   8'd7,   8'd9,   2'd1, 16'd15},
        {1'b1, 1'b0, 16'd1,      8'd3,   8'd5,   8'd7,   8'd9,   2'd1, 16'd16},
        {1'b1, 1'b0, 16'd2,      8'd255, 8'd255, 8'd1,   8'd1,   2'd1, 16'd65025},
        {1'b1, 1'b0, 16'd3,      8'd1,   8'd1,   8'd255, 8'd255, 2'd1, 16'd510},
        {1'b0, 1'b0, 16'd4,      8'd9,   8'd9,   8'd9,   8'd9,   2'd0, 16'd0},
        {1'b1, 1'b1, 16'd6,      8'd12,  8'd10,  8'd0,   8'd0,   2'd2, 16'd120},
        {1'b1, 1'b1, 16'd7,      8'd12,  8'd10,  8'd200, 8'd100, 2'd3, 16'd300},
        {1'b1, 1'b0, 16'hFFFF,   8'd2,   8'd3,   8'd4,   8'd5,   2'd1, 16'd9},
        {1'b1, 1'b0, 16'hFFFE,   8'd2,   8'd3,   8'd4,   8'd5,   2'd1, 16'd6},
        {1'b1, 1'b1, 16'd9,      8'd7,   8'd7,   8'd0,   8'd0,   2'd3, 16'd0},
        {1'b0, 1'b1, 16'd10,     8'd7,   8'd7,   8'd7,   8'd7,   2'd0, 16'd0},
        {1'b1, 1'b0, 16'd10,     8'd0,   8'd200, 8'd1,   8'd1,   2'd1, 16'd0}
    };

    function automatic string vec_tag(int k);
        case (k)
            0:       return "R1/R6";
            1:       return "R2/R6";
            2:       return "R1 max product";
            3:       return "R2 max sum";
            4:       return "R4";
            5:       return "R5 even";
            6:       return "R5 odd";
            7:       return "R9 idx 0xFFFF";
            8:       return "R9 idx 0xFFFE";
            9:       return "R5 odd zero";
            10:      return "R4 split idle";
            default: return "R1 zero operand";
        endcase
    endfunction

    task automatic drive_vec(int k);
        in_valid = VEC[k][67];
        in_split = VEC[k][66];
        in_idx   = VEC[k][65:50];
        in_w0    = VEC[k][49:42];
        in_w1    = VEC[k][41:34];
        in_w2    = VEC[k][33:26];
        in_w3    = VEC[k][25:18];
    endtask

    task automatic check_outs(int kind, logic [15:0] expv, string tag);
        logic        ok;
        logic [15:0] act;
        ok  = 1'b1;
        act = 16'd0;
        case (kind)
            0: ok = !res_valid && !prod_we && !sum_we;
            1: begin
                act = res_data;
                ok  = res_valid && !prod_we && !sum_we && res_data == expv;
            end
            2: begin
                act = prod_data;
                ok  = prod_we && !res_valid && !sum_we && prod_data == expv;
            end
            default: begin
                act = sum_data;
                ok  = sum_we && !res_valid && !prod_we && sum_data == expv;
            end
        endcase
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: res_valid=%0b prod_we=%0b sum_we=%0b data=%0d, expected kind=%0d data=%0d",
                     tag, res_valid, prod_we, sum_we, act, kind, expv);
        end
    endtask

    initial begin
        // R7: reset held with a live iteration offered
        in_valid = 1'b1;
        in_idx   = 16'd0;
        in_w0    = 8'd4;
        in_w1    = 8'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_outs(0, 16'd0, "R7 during reset");

        rst = 1'b0;
        drive_vec(0);
        // R3: table streamed back to back, one result per cycle
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            check_outs(int'(VEC[k][17:16]), VEC[k][15:0], $sformatf("R3 stream %s", vec_tag(k)));
            if (k + 1 < NVEC) begin
                drive_vec(k + 1);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check_outs(0, 16'd0, "R4 after stream");

        // R7: reset in the same cycle as a valid iteration swallows it
        in_valid = 1'b1;
        in_split = 1'b0;
        in_idx   = 16'd0;
        in_w0    = 8'd6;
        in_w1    = 8'd6;
        rst      = 1'b1;
        @(negedge clk);
        check_outs(0, 16'd0, "R7 mid-run reset");

        // R2: first iteration after reset is delivered normally
        rst    = 1'b0;
        in_idx = 16'd1;
        in_w2  = 8'd10;
        in_w3  = 8'd20;
        @(negedge clk);
        check_outs(1, 16'd30, "R2 after reset");

        in_valid = 1'b0;
        @(negedge clk);
        check_outs(0, 16'd0, "R4 final idle");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule